// File: doc/BRIEF.md
# Looping Audio Block Streamer

This block moves audio from memory to a sample sink in fixed 32-byte blocks, paced by an external 4 kHz tick. That rate delivers 32 kHz of 16-bit stereo frames, which are 4 bytes each. Software sets a start address and then writes a 16-bit control word. The low fifteen bits of that word give the buffer length in blocks, and the top bit turns streaming on. On every tick the block checks two conditions: streaming is on, and blocks remain. If both hold, it reads one block from memory as eight 32-bit words over a request/acknowledge port. It passes each word to a valid/ready stream in address order.

At the end of each block the remaining-block counter goes down by one and the read pointer moves forward 32 bytes. When the counter reaches zero, the buffer wraps. The block raises a one-cycle interrupt, reloads the counter from the programmed length and moves the pointer back to the start address. A looped buffer therefore plays with no further help from software. If a tick arrives while a block is still in flight, the tick is dropped and a sticky overflow flag is set. Any write to the control word clears that flag.

The sequencer has three states. IDLE waits for a tick. REQ holds a memory request until it is acknowledged. SEND offers the captured word on the stream. The transitions are:
- START (IDLE→REQ): a tick arrives while streaming is on and blocks remain.
- GRANT (REQ→SEND): the memory acknowledges.
- NEXT (SEND→REQ): a word that is not the last is accepted.
- DONE (SEND→IDLE): the eighth word is accepted.

Top module: `audio_block_streamer`

## Requirements
- R1: The control word carries the block count in bits 14:0 and the enable in bit 15. A write that turns the enable from 0 to 1 loads the remaining counter from bits 14:0 and the read pointer from the start address.
- R2: A tick that arrives while the enable is 0, or while the remaining counter is zero, causes no memory request and no stream output.
- R3: An accepted tick reads eight 32-bit words from byte addresses P, P+4, … P+28, where P is the read pointer. Those words appear on the stream in that order.
- R4: The memory request stays high, with a stable address, until the memory acknowledges it.
- R5: While the stream is stalled (valid high, ready low), valid stays high and the data stays unchanged.
- R6: Each completed block that does not empty the counter advances the read pointer by 32 bytes.
- R7: A block that takes the counter to zero raises `irq` for exactly one cycle, reloads the counter from the programmed count and moves the pointer back to the start address.
- R8: A tick that arrives while a block is in flight is dropped and sets `overflow`. The flag stays set until the next control write, which clears it.
- R9: Clearing the enable in the middle of a block lets that block finish all eight words. No later tick starts a block.
- R10: Writing a new count while the enable stays 1 does not reload the counter. The new count takes effect at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | CNT_W+1 | Control word: enable in MSB, block count below it |
| base_we | input | 1 | Start address write strobe |
| base_wdata | input | AW | Buffer start byte address |
| tick | input | 1 | One-cycle block-rate pulse (4 kHz) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read byte address |
| mem_ack | input | 1 | Memory read acknowledge, with data |
| mem_rdata | input | DW | Memory read data |
| out_valid | output | 1 | Stream word valid |
| out_data | output | DW | Stream word |
| out_ready | input | 1 | Stream sink ready |
| irq | output | 1 | One-cycle pulse at each buffer wrap |
| overflow | output | 1 | Sticky flag: a tick was dropped while a block was in flight |

## Verification
A wrong remaining count or read pointer shows at the ports within one block. The next block's eight words come from the wrong addresses, and the interrupt fires one block too early or too late. The bench therefore checks every word of every block against the address it should have come from, and counts interrupt cycles at each wrap. A wrong sequencer state shows as a stalled word changing, extra or missing words, or a dropped tick still producing data. These are checked during stalls, after overflow, and after the enable is cleared.

// File: rtl/abs_pkg.sv
package abs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SEND = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/abs_block_tracker.sv
module abs_block_tracker #(
    parameter int AW          = 32,
    parameter int CNT_W       = 15,
    parameter int BLOCK_BYTES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [CNT_W-1:0] ctrl_count,
    input  logic             ctrl_enable,
    input  logic             base_we,
    input  logic [AW-1:0]    base_wdata,
    input  logic             blk_done,
    output logic             go_ok,
    output logic [AW-1:0]    blk_ptr,
    output logic             irq
);
    localparam logic [AW-1:0]    STEP = AW'(BLOCK_BYTES);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] prog_count_q;
    logic [CNT_W-1:0] remain_q;
    logic             enable_q;
    logic [AW-1:0]    start_q;
    logic [AW-1:0]    ptr_q;
    logic [AW-1:0]    start_next;
    logic             arm;

    assign start_next = base_we ? base_wdata : start_q;
    assign arm        = ctrl_we && ctrl_enable && !enable_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_count_q <= '0;
            enable_q     <= 1'b0;
            start_q      <= '0;
        end else begin
            if (ctrl_we) begin
                prog_count_q <= ctrl_count;
                enable_q     <= ctrl_enable;
            end
            if (base_we) begin
                start_q <= base_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            ptr_q    <= '0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (arm) begin
                remain_q <= ctrl_count;
                ptr_q    <= start_next;
            end else if (blk_done && remain_q != '0) begin
                if (remain_q == ONE) begin
                    remain_q <= prog_count_q;
                    ptr_q    <= start_q;
                    irq      <= 1'b1;
                end else begin
                    remain_q <= remain_q - ONE;
                    ptr_q    <= ptr_q + STEP;
                end
            end
        end
    end

    assign go_ok   = enable_q && (remain_q != '0);
    assign blk_ptr = ptr_q;

    // R7
    irq_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(blk_done));

    // R10
    no_reload_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && enable_q && !blk_done) |=> $stable(remain_q));
endmodule

// File: rtl/abs_fetch_fsm.sv
module abs_fetch_fsm
    import abs_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          go_ok,
    input  logic [AW-1:0] blk_ptr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready,
    output logic          busy,
    output logic          blk_done
);
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int SH    = $clog2(DW / 8);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    fetch_state_t state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [AW-1:0]    base_q;
    logic [DW-1:0]    data_q;
    logic             last_word;

    assign last_word = (idx_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tick && go_ok)            state_d = ST_REQ;
            ST_REQ:  if (mem_ack)                  state_d = ST_SEND;
            ST_SEND: if (out_ready)                state_d = last_word ? ST_IDLE : ST_REQ;
            default:                               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            base_q <= '0;
            data_q <= '0;
        end else begin
            if (state_q == ST_IDLE && tick && go_ok) begin
                idx_q  <= '0;
                base_q <= blk_ptr;
            end
            if (state_q == ST_REQ && mem_ack) begin
                data_q <= mem_rdata;
            end
            if (state_q == ST_SEND && out_ready && !last_word) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        out_valid = 1'b0;
        blk_done  = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: busy      = 1'b0;
            ST_REQ:  mem_req   = 1'b1;
            ST_SEND: begin
                out_valid = 1'b1;
                blk_done  = out_ready && last_word;
            end
            default: busy      = 1'b0;
        endcase
    end

    assign mem_addr = base_q + (AW'(idx_q) << SH);
    assign out_data = data_q;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R2
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go_ok) |=> !mem_req);
endmodule

// File: rtl/audio_block_streamer.sv
module audio_block_streamer #(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int CNT_W       = 15,
    parameter int BLOCK_BYTES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [CNT_W:0]   ctrl_wdata,
    input  logic             base_we,
    input  logic [AW-1:0]    base_wdata,
    input  logic             tick,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    input  logic             out_ready,
    output logic             irq,
    output logic             overflow
);
    localparam int WORDS = BLOCK_BYTES / (DW / 8);

    logic          go_ok;
    logic [AW-1:0] blk_ptr;
    logic          busy;
    logic          blk_done;
    logic          ovf_q;

    abs_block_tracker #(
        .AW(AW), .CNT_W(CNT_W), .BLOCK_BYTES(BLOCK_BYTES)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_count (ctrl_wdata[CNT_W-1:0]),
        .ctrl_enable(ctrl_wdata[CNT_W]),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .blk_done   (blk_done),
        .go_ok      (go_ok),
        .blk_ptr    (blk_ptr),
        .irq        (irq)
    );

    abs_fetch_fsm #(
        .AW(AW), .DW(DW), .WORDS(WORDS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .go_ok    (go_ok),
        .blk_ptr  (blk_ptr),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_ready(out_ready),
        .busy     (busy),
        .blk_done (blk_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (tick && busy) begin
            ovf_q <= 1'b1;
        end else if (ctrl_we) begin
            ovf_q <= 1'b0;
        end
    end

    assign overflow = ovf_q;

    // R8
    drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && busy) |=> overflow);

    // R8
    drop_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && busy && !blk_done) |=> busy);
endmodule

// File: tb/sim_audio_block_streamer.sv
`timescale 1ns/1ps
module sim_audio_block_streamer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        tick = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b1;
    logic        irq;
    logic        overflow;

    int errors = 0;
    int checks = 0;
    logic [31:0] got [0:63];
    int got_n = 0;
    int irq_cyc = 0;
    int req_cyc = 0;

    always #2 clk = ~clk;

    audio_block_streamer u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .base_we(base_we), .base_wdata(base_wdata), .tick(tick),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .irq(irq), .overflow(overflow)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= pat(mem_addr);
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready && got_n < 64) begin
                got[got_n] = out_data;
                got_n = got_n + 1;
            end
            if (irq) irq_cyc = irq_cyc + 1;
            if (mem_req) req_cyc = req_cyc + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        got_n = 0;
        irq_cyc = 0;
        req_cyc = 0;
    endtask

    task automatic write_ctrl(input bit en, input int cnt);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = {en, 15'(cnt)};
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic write_base(input logic [31:0] a);
        @(negedge clk);
        base_we = 1'b1;
        base_wdata = a;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic expect_block(input logic [31:0] base, input string req);
        check(got_n == 8, "R4", got_n, 8);
        for (int i = 0; i < 8; i++) begin
            if (i < got_n)
                check(got[i] == pat(base + 32'(4 * i)), req, got[i], pat(base + 32'(4 * i)));
        end
    endtask

    task automatic run_block(input logic [31:0] base, input string req, input int irq_exp);
        clear_log();
        pulse_tick();
        repeat (60) @(negedge clk);
        expect_block(base, req);
        check(irq_cyc == irq_exp, "R7", irq_cyc, irq_exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!mem_req && !out_valid && !irq && !overflow, "R2",
              {mem_req, out_valid, irq, overflow}, 0);
    endtask

    task automatic t_disabled();
        write_base(32'h1000);
        write_ctrl(1'b0, 2);
        clear_log();
        pulse_tick();
        repeat (40) @(negedge clk);
        check(got_n == 0 && req_cyc == 0, "R2", got_n + req_cyc, 0);
    endtask

    task automatic t_stream();
        write_ctrl(1'b1, 3);                  // R1 enable rise loads count 3, ptr 0x1000
        run_block(32'h1000, "R3", 0);
        run_block(32'h1020, "R6", 0);
        run_block(32'h1040, "R6", 1);         // R7 wrap
        run_block(32'h1000, "R7", 0);         // R7 pointer back to start
    endtask

    task automatic t_count_change();
        write_ctrl(1'b1, 2);                  // R10 no reload, remaining stays 2
        run_block(32'h1020, "R10", 0);
        run_block(32'h1040, "R10", 1);
        run_block(32'h1000, "R10", 0);
        run_block(32'h1020, "R10", 1);        // new count 2 used at wrap
    endtask

    task automatic t_overflow();
        logic [31:0] held;
        clear_log();
        @(negedge clk);
        out_ready = 1'b0;
        pulse_tick();
        repeat (10) @(negedge clk);
        check(overflow == 1'b0, "R8", overflow, 0);
        check(out_valid == 1'b1, "R5", out_valid, 1);
        held = out_data;
        pulse_tick();
        @(negedge clk);
        check(overflow == 1'b1, "R8", overflow, 1);
        repeat (5) @(negedge clk);
        check(out_valid == 1'b1 && out_data == held, "R5", out_data, held);
        check(held == pat(32'h1000), "R5", held, pat(32'h1000));
        out_ready = 1'b1;
        repeat (80) @(negedge clk);
        expect_block(32'h1000, "R8");         // dropped tick made no second block
        run_block(32'h1020, "R8", 1);
        check(overflow == 1'b1, "R8", overflow, 1);
        write_ctrl(1'b1, 2);
        check(overflow == 1'b0, "R8", overflow, 0);
    endtask

    task automatic t_disable();
        clear_log();
        pulse_tick();
        repeat (4) @(negedge clk);
        write_ctrl(1'b0, 2);
        repeat (60) @(negedge clk);
        expect_block(32'h1000, "R9");
        clear_log();
        pulse_tick();
        repeat (40) @(negedge clk);
        check(got_n == 0 && req_cyc == 0, "R9", got_n + req_cyc, 0);
    endtask

    task automatic t_rearm();
        write_base(32'h2000);
        write_ctrl(1'b1, 1);                  // R1 fresh load from new start
        run_block(32'h2000, "R1", 1);
        run_block(32'h2000, "R7", 1);
        write_ctrl(1'b0, 1);
        write_ctrl(1'b1, 0);                  // R2 enabled with count zero
        clear_log();
        pulse_tick();
        repeat (40) @(negedge clk);
        check(got_n == 0 && req_cyc == 0, "R2", got_n + req_cyc, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_stream();
        t_count_change();
        t_overflow();
        t_disable();
        t_rearm();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule